// File: doc/BRIEF.md
# Claim-Wire Bus Ownership Arbiter

This block decides whether the local master may drive a shared I2C bus when several masters sit on it. It does not use the usual SDA-level arbitration. Each master has its own claim wire. The wires are active low and pulled up, so a released wire reads high. When the local side asks for the bus, the block pulls its own claim wire low. It then waits a settle time and looks at the claim wires of the other masters. If they are all high, it owns the bus. If any of them is low, it waits a re-check window and looks again. If the other claim is still present after that window, the block backs off. It releases its own wire, waits a back-off time, and tries again from the start.

One deadline covers the whole attempt. The deadline counter starts at the first claim assertion and is not restarted by retries. When it expires, the block drops its claim and pulses an error for one clock. Once the bus is owned, the grant and the claim stay asserted until the local release input arrives.

All delays are given in microseconds. A tick generator derived from the clock-frequency parameter turns them into clock cycles. The other-master inputs pass through a two-flop synchronizer before the sequencer uses them.

Top module: `bus_claim_arbiter`

## Requirements
- R1: After reset, `claim_n_o` is 1 (released), `grant_o` is 0 and `timeout_o` is 0.
- R2: When `req_i` is high at a clock edge while the block is idle, `claim_n_o` is 0 after that edge (edge E0).
- R3: With P = CLK_HZ/1e6 cycles per microsecond, the other claim inputs are evaluated at edge E(SLEW_US·P). If all of them are seen high, `grant_o` is 1 after that edge and not before.
- R4: The other claim inputs pass through two flops before evaluation. A change is seen at an evaluation edge only if it was applied before the edge two edges earlier. A change applied one edge before the evaluation edge is not seen.
- R5: Contention is declared when any single bit of `other_claim_n_i` is 0, whichever bit it is.
- R6: On contention at the settle check, the inputs are evaluated again SETTLE_US·0 + RECHECK_US·P cycles later, at edge E((SLEW_US+RECHECK_US)·P). If all inputs are seen high there, `grant_o` is 1 after that edge.
- R7: If contention is still present at the re-check, `claim_n_o` goes to 1 after that edge. After BACKOFF_US·P further cycles it goes back to 0, and the settle step restarts.
- R8: At edge E(GIVEUP_US·P), counted from the first claim assertion and not restarted by retries, a claim still without grant ends. `claim_n_o` goes to 1, `timeout_o` is 1 for exactly one cycle, and `grant_o` stays 0.
- R9: While granted, `grant_o` and a low `claim_n_o` hold until `rel_i` is high at an edge. After that edge, `grant_o` is 0 and `claim_n_o` is 1.
- R10: When `rel_i` is high during a claim that has no grant yet, the attempt is aborted at that edge. `claim_n_o` goes to 1, no grant follows, and `timeout_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Start a claim attempt when idle |
| rel_i | input | 1 | Give up the bus or abort an attempt |
| other_claim_n_i | input | N_OTHERS | Claim wires of the other masters, active low |
| claim_n_o | output | 1 | Local claim wire, active low |
| grant_o | output | 1 | Local master owns the bus |
| timeout_o | output | 1 | One-cycle pulse when the deadline ends an attempt |

## Verification
Every result is timed from the edge that accepts the request, E0. The claim output changes right after E0. Each evaluation and each back-off boundary lands on a multiple of P cycles after E0, and the deadline lands on GIVEUP_US·P. Release takes effect one edge after it is applied. The bench drives inputs and samples outputs on falling edges. It counts the rising edges since E0 and checks the output just before and just after each edge where a change is due. To cover the two-flop latency, it moves a contention edge by one cycle on either side of the settle check.

// File: rtl/bca_pkg.sv
package bca_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETTLE,
      ST_RECHECK,
      ST_BACKOFF,
      ST_OWNED
   } bca_state_e;
endpackage

// File: rtl/bca_us_tick.sv
module bca_us_tick #(
   parameter int CYC_PER_US = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic tick_o
);
   localparam int CW = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
   localparam logic [CW-1:0] LAST = CW'(CYC_PER_US - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt_q <= '0;
      else if (!run_i)      cnt_q <= '0;
      else if (cnt_q == LAST) cnt_q <= '0;
      else                  cnt_q <= cnt_q + 1'b1;
   end

   assign tick_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/bca_sync.sv
module bca_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] stg_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg_q[s] <= '1;
         else if (s == 0) stg_q[s] <= d_i;
         else stg_q[s] <= stg_q[(s > 0) ? s - 1 : 0];
      end
   end

   assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/bca_fsm.sv
module bca_fsm
   import bca_pkg::*;
#(
   parameter int SLEW_US    = 10,
   parameter int RECHECK_US = 2000,
   parameter int BACKOFF_US = 3000,
   parameter int GIVEUP_US  = 50000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic contend_i,
   input  logic req_i,
   input  logic rel_i,
   output logic run_o,
   output logic claim_n_o,
   output logic grant_o,
   output logic timeout_o
);
   localparam int MAXPH = (SLEW_US > RECHECK_US) ?
                          ((SLEW_US > BACKOFF_US) ? SLEW_US : BACKOFF_US) :
                          ((RECHECK_US > BACKOFF_US) ? RECHECK_US : BACKOFF_US);
   localparam int PW = $clog2(MAXPH + 1);
   localparam int DW = $clog2(GIVEUP_US + 1);
   localparam logic [PW-1:0] S_LAST = PW'(SLEW_US - 1);
   localparam logic [PW-1:0] R_LAST = PW'(RECHECK_US - 1);
   localparam logic [PW-1:0] B_LAST = PW'(BACKOFF_US - 1);
   localparam logic [DW-1:0] D_LAST = DW'(GIVEUP_US - 1);

   bca_state_e    st_q;
   logic [PW-1:0] ph_q;
   logic [DW-1:0] dl_q;
   logic          claim_n_q;
   logic          err_q;
   logic [PW-1:0] ph_last;

   always_comb begin
      unique case (st_q)
         ST_SETTLE:  ph_last = S_LAST;
         ST_RECHECK: ph_last = R_LAST;
         default:    ph_last = B_LAST;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         ph_q      <= '0;
         dl_q      <= '0;
         claim_n_q <= 1'b1;
         err_q     <= 1'b0;
      end else begin
         err_q <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (req_i) begin
                  st_q      <= ST_SETTLE;
                  claim_n_q <= 1'b0;
                  ph_q      <= '0;
                  dl_q      <= '0;
               end
            end
            ST_OWNED: begin
               if (rel_i) begin
                  st_q      <= ST_IDLE;
                  claim_n_q <= 1'b1;
               end
            end
            default: begin
               if (rel_i) begin
                  st_q      <= ST_IDLE;
                  claim_n_q <= 1'b1;
               end else if (tick_i) begin
                  if (dl_q == D_LAST) begin
                     st_q      <= ST_IDLE;
                     claim_n_q <= 1'b1;
                     err_q     <= 1'b1;
                  end else begin
                     dl_q <= dl_q + 1'b1;
                     if (ph_q == ph_last) begin
                        ph_q <= '0;
                        unique case (st_q)
                           ST_SETTLE:  st_q <= contend_i ? ST_RECHECK : ST_OWNED;
                           ST_RECHECK: begin
                              if (contend_i) begin
                                 st_q      <= ST_BACKOFF;
                                 claim_n_q <= 1'b1;
                              end else begin
                                 st_q <= ST_OWNED;
                              end
                           end
                           default: begin
                              st_q      <= ST_SETTLE;
                              claim_n_q <= 1'b0;
                           end
                        endcase
                     end else begin
                        ph_q <= ph_q + 1'b1;
                     end
                  end
               end
            end
         endcase
      end
   end

   assign run_o     = (st_q == ST_SETTLE) || (st_q == ST_RECHECK) || (st_q == ST_BACKOFF);
   assign grant_o   = (st_q == ST_OWNED);
   assign claim_n_o = claim_n_q;
   assign timeout_o = err_q;
endmodule

// File: rtl/bus_claim_arbiter.sv
module bus_claim_arbiter #(
   parameter int CLK_HZ      = 100_000_000,
   parameter int N_OTHERS    = 1,
   parameter int SYNC_STAGES = 2,
   parameter int SLEW_US     = 10,
   parameter int RECHECK_US  = 2000,
   parameter int BACKOFF_US  = 3000,
   parameter int GIVEUP_US   = 50000
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_i,
   input  logic                rel_i,
   input  logic [N_OTHERS-1:0] other_claim_n_i,
   output logic                claim_n_o,
   output logic                grant_o,
   output logic                timeout_o
);
   localparam int CYC_PER_US = CLK_HZ / 1_000_000;

   if (CYC_PER_US < 1) begin : g_bad_clk
      $error("CLK_HZ must be at least 1 MHz");
   end
   if (N_OTHERS < 1) begin : g_bad_n
      $error("N_OTHERS must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (SLEW_US < 1 || RECHECK_US < 1 || BACKOFF_US < 1) begin : g_bad_dly
      $error("all delays must be at least 1 us");
   end
   if (GIVEUP_US <= SLEW_US) begin : g_bad_giveup
      $error("GIVEUP_US must exceed SLEW_US");
   end

   logic [N_OTHERS-1:0] others_s;
   logic                tick;
   logic                run;
   logic                contend;

   bca_sync #(.W(N_OTHERS), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (other_claim_n_i),
      .q_o   (others_s)
   );

   assign contend = ~&others_s;

   bca_us_tick #(.CYC_PER_US(CYC_PER_US)) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (run),
      .tick_o (tick)
   );

   bca_fsm #(
      .SLEW_US    (SLEW_US),
      .RECHECK_US (RECHECK_US),
      .BACKOFF_US (BACKOFF_US),
      .GIVEUP_US  (GIVEUP_US)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_i    (tick),
      .contend_i (contend),
      .req_i     (req_i),
      .rel_i     (rel_i),
      .run_o     (run),
      .claim_n_o (claim_n_o),
      .grant_o   (grant_o),
      .timeout_o (timeout_o)
   );
endmodule

// File: rtl/bca_chk.sv
module bca_chk (
   input logic clk,
   input logic rst_n,
   input logic req_i,
   input logic rel_i,
   input logic claim_n_o,
   input logic grant_o,
   input logic timeout_o
);
   // R9
   grant_holds_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
      grant_o |-> !claim_n_o);

   // R8
   timeout_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_o |=> !timeout_o);

   // R8
   timeout_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_o |-> (claim_n_o && !grant_o));

   // R3
   grant_after_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(grant_o) |-> $past(!claim_n_o));

   // R9
   release_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_o && rel_i) |=> (!grant_o && claim_n_o));

   // R9
   grant_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_o && !rel_i) |=> grant_o);

   // R10
   abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!claim_n_o && !grant_o && rel_i) |=> (claim_n_o && !timeout_o));

   // R2
   idle_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (claim_n_o && !grant_o && req_i && !$past(!claim_n_o)) |=> !claim_n_o);
endmodule

bind bus_claim_arbiter bca_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_i     (req_i),
   .rel_i     (rel_i),
   .claim_n_o (claim_n_o),
   .grant_o   (grant_o),
   .timeout_o (timeout_o)
);

// File: tb/sim_bus_claim_arbiter.sv
`timescale 1ns/1ps
module sim_bus_claim_arbiter;
   localparam int CLK_HZ = 125_000_000;
   localparam int P      = CLK_HZ / 1_000_000;
   localparam int S      = 2;
   localparam int R      = 3;
   localparam int B      = 4;
   localparam int G      = 40;
   localparam int EV_S   = S * P;
   localparam int EV_R   = (S + R) * P;
   localparam int ROUND  = (S + R + B) * P;
   localparam int DEAD   = G * P;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req = 1'b0;
   logic       rel = 1'b0;
   logic [1:0] others = 2'b11;
   logic       claim_n, grant, tmo;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   bus_claim_arbiter #(
      .CLK_HZ(CLK_HZ), .N_OTHERS(2), .SYNC_STAGES(2),
      .SLEW_US(S), .RECHECK_US(R), .BACKOFF_US(B), .GIVEUP_US(G)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .req_i(req), .rel_i(rel),
      .other_claim_n_i(others), .claim_n_o(claim_n), .grant_o(grant), .timeout_o(tmo)
   );

   task automatic step(input int n);
      for (int i = 0; i < n; i++) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string tag, input string what, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
      end
   endtask

   // pulse req at a falling edge; returns just after edge E0
   task automatic start();
      req = 1'b1;
      step(1);
      req = 1'b0;
   endtask

   task automatic release_bus();
      rel = 1'b1;
      step(1);
      rel = 1'b0;
   endtask

   initial begin
      step(3);
      // R1
      chk("R1", "claim_n", claim_n, 1'b1);
      chk("R1", "grant", grant, 1'b0);
      chk("R1", "timeout", tmo, 1'b0);
      rst_n = 1'b1;
      step(2);

      // R2, R3: free bus
      start();
      chk("R2", "claim_n at E0", claim_n, 1'b0);
      step(EV_S - 1);
      chk("R3", "grant before settle", grant, 1'b0);
      step(1);
      chk("R3", "grant at settle", grant, 1'b1);
      step(300);
      chk("R9", "grant held", grant, 1'b1);
      chk("R9", "claim held", claim_n, 1'b0);
      release_bus();
      chk("R9", "grant after release", grant, 1'b0);
      chk("R9", "claim after release", claim_n, 1'b1);
      step(5);

      // R4: contention applied early enough, then R6 recheck clears
      start();
      step(EV_S - 3);
      others[0] = 1'b0;
      step(3);
      chk("R4", "grant with late-seen contention", grant, 1'b0);
      chk("R4", "claim kept", claim_n, 1'b0);
      others = 2'b11;
      step(EV_R - EV_S - 1);
      chk("R6", "grant before recheck", grant, 1'b0);
      step(1);
      chk("R6", "grant at recheck", grant, 1'b1);
      release_bus();
      step(5);

      // R4: contention one edge too late is not seen
      start();
      step(EV_S - 2);
      others[0] = 1'b0;
      step(2);
      chk("R4", "grant with unseen contention", grant, 1'b1);
      others = 2'b11;
      release_bus();
      step(5);

      // R5, R7: other bit contends, back-off and retry
      others = 2'b01;
      step(3);
      start();
      step(EV_S);
      chk("R5", "no grant on bit1 contention", grant, 1'b0);
      step(EV_R - EV_S - 1);
      chk("R7", "claim before backoff", claim_n, 1'b0);
      step(1);
      chk("R7", "claim released at backoff", claim_n, 1'b1);
      chk("R7", "no grant at backoff", grant, 1'b0);
      step(ROUND - EV_R - 1);
      chk("R7", "claim still released", claim_n, 1'b1);
      step(1);
      chk("R7", "claim reasserted", claim_n, 1'b0);
      others = 2'b11;
      step(EV_S - 1);
      chk("R7", "grant before retry settle", grant, 1'b0);
      step(1);
      chk("R7", "grant after retry settle", grant, 1'b1);
      release_bus();
      step(5);

      // R8: persistent contention, deadline spans retries
      others = 2'b10;
      step(3);
      start();
      step(DEAD - 1);
      chk("R8", "timeout before deadline", tmo, 1'b0);
      chk("R8", "claim before deadline", claim_n, 1'b0);
      step(1);
      chk("R8", "timeout at deadline", tmo, 1'b1);
      chk("R8", "claim at deadline", claim_n, 1'b1);
      chk("R8", "grant at deadline", grant, 1'b0);
      step(1);
      chk("R8", "timeout one cycle", tmo, 1'b0);
      step(ROUND);
      chk("R8", "claim stays released", claim_n, 1'b1);
      others = 2'b11;
      step(5);

      // R10: abort during settle
      start();
      step(100);
      release_bus();
      chk("R10", "claim after abort", claim_n, 1'b1);
      step(EV_S + 50);
      chk("R10", "no grant after abort", grant, 1'b0);
      chk("R10", "no timeout after abort", tmo, 1'b0);
      chk("R10", "claim stays released", claim_n, 1'b1);

      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 100_000; i++) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule